// File: doc/BRIEF.md
# State-Selected Weight Refresh Sequencer

This block keeps the stored weights of an analog network array up to date, and it picks which weight set the array holds from the plant's current discrete state. A small programmable automaton reads a few binary plant signals, together with one comparison bit per control output. Each comparison bit says whether that output is strictly above its own threshold. On every step pulse the automaton moves to a new state and selects one of several weight sets, each held in its own region of an external weight memory.

A row sequencer reads the selected set one row at a time. Each row is a single wide memory word that holds one byte for every converter channel. The sequencer hands that row to the converter bank in parallel and then waits for the bank to acknowledge the update. New rows start only inside the idle part of the pulse frame, and only in frames picked by a programmable interval: every frame, or one frame in every gap+1.

A watchdog tracks how long each row has gone without a refresh. It raises an alarm while any row has been stale for too long.

Top module: `wset_refresh_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output register clears: `mem_rd`, `mem_addr`, `dac_wr`, `dac_row`, `dac_data`, `fsa_state`, `wset` and `wd_alarm` are all zero after that edge.
- R2: Comparison bit i is 1 only when control word i is strictly greater than threshold word i, both unsigned. Equal values give 0. The input vector is {comparison bits, `bin_i`}, with `bin_i` in the low bits. On an edge with `step_i` high, the table entry at index {`fsa_state`, vector} is loaded. Its bits [5:3] go to `fsa_state` and its bits [2:0] go to `wset`. `cfg_we` writes `cfg_data` into entry `cfg_addr`.
- R3: Without `step_i`, `fsa_state` and `wset` keep their values.
- R4: A row read (`mem_rd` high for one cycle) starts only from the idle sequencer state, in a cycle after a rising edge of `idle_phase` that opened a selected window, with `idle_phase` still high at the issuing edge. Idle windows are counted from reset, and windows 0, g+1, 2(g+1), … are selected, where g is `frame_gap`.
- R5: The read address is {set, row}. The set is the `wset` value at the issuing edge and occupies the high 3 bits; the row index occupies the low 5 bits.
- R6: The memory returns a row one cycle after `mem_rd`. Exactly two cycles after `mem_rd`, `dac_wr` pulses for one cycle, with `dac_data` equal to the returned row and `dac_row` equal to the row index read.
- R7: After `dac_wr`, no further read starts until `dac_ack` has been seen. Only one row is ever in flight.
- R8: Rows of the same set are refreshed in ascending order, and the index wraps from the last row back to 0.
- R9: If `wset` differs from the set of the row in flight when `dac_ack` arrives, that row still completes with its old data, and the next row is row 0 of the new set.
- R10: Each row keeps a saturating age count of clock cycles. The count clears in the cycle after that row's `dac_wr`. `wd_alarm` is registered and goes high in the cycle after any age count is at or above `wd_limit`.
- R11: A row that has started completes its write and acknowledge even if `idle_phase` falls while it is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Automaton evaluation strobe |
| bin_i | input | 2 | Binary plant inputs |
| ctl_i | input | 16 | Two unsigned 8-bit control outputs |
| thr_i | input | 16 | Two unsigned 8-bit thresholds |
| cfg_we | input | 1 | Transition table write enable |
| cfg_addr | input | 7 | Table index {state, vector} |
| cfg_data | input | 6 | Table entry {next state, weight set} |
| idle_phase | input | 1 | High during the idle phase of the pulse frame |
| frame_gap | input | 4 | Refresh interval: windows skipped between refresh windows |
| wd_limit | input | 16 | Staleness limit in cycles |
| mem_rd | output | 1 | Weight memory read strobe |
| mem_addr | output | 8 | Weight memory row address |
| mem_rdata | input | 256 | Row data, valid one cycle after the read |
| dac_wr | output | 1 | Converter bank write strobe |
| dac_row | output | 5 | Row index being written |
| dac_data | output | 256 | Thirty-two 8-bit converter codes |
| dac_ack | input | 1 | Converter bank update done |
| fsa_state | output | 3 | Current automaton state |
| wset | output | 3 | Selected weight set |
| wd_alarm | output | 1 | Some row exceeds the staleness limit |

## Verification
Step pulses arrive at irregular times relative to the frame. This places set changes both between rows and while a row waits for its acknowledge, which separates the restart-at-row-0 path from plain row advance. Control words are stepped through values that fall below, on and above each threshold, so a comparator that uses greater-or-equal will diverge. The run uses an every-frame interval, a one-in-three interval and a long stretch with no steps. The last of these forces rows to wrap and shows that the state holds. Together they separate window selection from window gating and let staleness build until the alarm rises.

// File: rtl/wr_pkg.sv
package wr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_READ = 2'd1,
    SQ_LOAD = 2'd2,
    SQ_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/wr_fsa.sv
module wr_fsa #(
  parameter int BIN_N = 2,
  parameter int THR_N = 2,
  parameter int OUT_W = 8,
  parameter int ST_W  = 3,
  parameter int SET_W = 3,
  localparam int VEC_W = BIN_N + THR_N,
  localparam int IDX_W = ST_W + VEC_W,
  localparam int ENT_W = ST_W + SET_W,
  localparam int TBL_D = 1 << IDX_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_addr,
  input  logic [ENT_W-1:0]       cfg_data,
  input  logic                   step,
  input  logic [BIN_N-1:0]       bin,
  input  logic [THR_N*OUT_W-1:0] ctl,
  input  logic [THR_N*OUT_W-1:0] thr,
  output logic [ST_W-1:0]        state_q,
  output logic [SET_W-1:0]       set_q
);
  logic [THR_N-1:0] above;
  logic [ENT_W-1:0] table_q [TBL_D];
  logic [ENT_W-1:0] entry;

  for (genvar i = 0; i < THR_N; i++) begin : g_cmp
    assign above[i] = ctl[i*OUT_W +: OUT_W] > thr[i*OUT_W +: OUT_W];
  end

  always_ff @(posedge clk) begin
    if (cfg_we) table_q[cfg_addr] <= cfg_data;
  end

  assign entry = table_q[{state_q, above, bin}];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= '0;
      set_q   <= '0;
    end else if (step) begin
      state_q <= entry[ENT_W-1:SET_W];
      set_q   <= entry[SET_W-1:0];
    end
  end
endmodule

// File: rtl/wr_frame_gate.sv
module wr_frame_gate #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idle,
  input  logic [GAP_W-1:0] gap,
  output logic             win_q
);
  logic             idle_d;
  logic [GAP_W-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_d <= 1'b0;
      fcnt   <= '0;
      win_q  <= 1'b0;
    end else begin
      idle_d <= idle;
      if (idle && !idle_d) begin
        win_q <= (fcnt == '0);
        fcnt  <= (fcnt >= gap) ? '0 : fcnt + 1'b1;
      end else if (!idle) begin
        win_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wr_row_seq.sv
module wr_row_seq
  import wr_pkg::*;
#(
  parameter int SET_W  = 3,
  parameter int ROW_W  = 5,
  parameter int ROWS   = 32,
  parameter int DATA_W = 256,
  localparam int ADDR_W = SET_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win,
  input  logic              idle,
  input  logic [SET_W-1:0]  cur_set,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dac_wr,
  output logic [ROW_W-1:0]  dac_row,
  output logic [DATA_W-1:0] dac_data,
  input  logic              dac_ack
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

  seq_state_t       st;
  logic [ROW_W-1:0] row;
  logic [SET_W-1:0] row_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= SQ_IDLE;
      row      <= '0;
      row_set  <= '0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
      dac_wr   <= 1'b0;
      dac_row  <= '0;
      dac_data <= '0;
    end else begin
      unique case (st)
        SQ_IDLE: if (win && idle) begin
          mem_rd   <= 1'b1;
          mem_addr <= {cur_set, row};
          row_set  <= cur_set;
          st       <= SQ_READ;
        end
        SQ_READ: begin
          mem_rd <= 1'b0;
          st     <= SQ_LOAD;
        end
        SQ_LOAD: begin
          dac_wr   <= 1'b1;
          dac_data <= mem_rdata;
          dac_row  <= row;
          st       <= SQ_WAIT;
        end
        SQ_WAIT: begin
          dac_wr <= 1'b0;
          if (dac_ack) begin
            if (cur_set != row_set) row <= '0;
            else if (row == LAST_ROW) row <= '0;
            else row <= row + 1'b1;
            st <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wr_row_watchdog.sv
module wr_row_watchdog #(
  parameter int ROWS  = 32,
  parameter int ROW_W = 5,
  parameter int AGE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [ROW_W-1:0] wr_row,
  input  logic [AGE_W-1:0] limit,
  output logic             alarm_q
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] age [ROWS];
  logic [ROWS-1:0]  stale;

  for (genvar r = 0; r < ROWS; r++) begin : g_age
    assign stale[r] = age[r] >= limit;
    always_ff @(posedge clk) begin
      if (rst) age[r] <= '0;
      else if (wr && wr_row == ROW_W'(r)) age[r] <= '0;
      else if (age[r] != AGE_MAX) age[r] <= age[r] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) alarm_q <= 1'b0;
    else     alarm_q <= |stale;
  end
endmodule

// File: rtl/wset_refresh_seq.sv
module wset_refresh_seq #(
  parameter int BIN_N   = 2,
  parameter int THR_N   = 2,
  parameter int OUT_W   = 8,
  parameter int NUM_ST  = 8,
  parameter int NUM_SET = 8,
  parameter int ROWS    = 32,
  parameter int COLS    = 32,
  parameter int DAC_W   = 8,
  parameter int AGE_W   = 16,
  parameter int GAP_W   = 4,
  localparam int ST_W   = $clog2(NUM_ST),
  localparam int SET_W  = $clog2(NUM_SET),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int IDX_W  = ST_W + BIN_N + THR_N,
  localparam int ENT_W  = ST_W + SET_W,
  localparam int ADDR_W = SET_W + ROW_W,
  localparam int DATA_W = COLS * DAC_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   step_i,
  input  logic [BIN_N-1:0]       bin_i,
  input  logic [THR_N*OUT_W-1:0] ctl_i,
  input  logic [THR_N*OUT_W-1:0] thr_i,
  input  logic                   cfg_we,
  input  logic [IDX_W-1:0]       cfg_addr,
  input  logic [ENT_W-1:0]       cfg_data,
  input  logic                   idle_phase,
  input  logic [GAP_W-1:0]       frame_gap,
  input  logic [AGE_W-1:0]       wd_limit,
  output logic                   mem_rd,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   dac_wr,
  output logic [ROW_W-1:0]       dac_row,
  output logic [DATA_W-1:0]      dac_data,
  input  logic                   dac_ack,
  output logic [ST_W-1:0]        fsa_state,
  output logic [SET_W-1:0]       wset,
  output logic                   wd_alarm
);
  logic win;

  wr_fsa #(.BIN_N(BIN_N), .THR_N(THR_N), .OUT_W(OUT_W), .ST_W(ST_W), .SET_W(SET_W)) u_fsa (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .step(step_i), .bin(bin_i), .ctl(ctl_i), .thr(thr_i),
    .state_q(fsa_state), .set_q(wset)
  );

  wr_frame_gate #(.GAP_W(GAP_W)) u_gate (
    .clk(clk), .rst(rst), .idle(idle_phase), .gap(frame_gap), .win_q(win)
  );

  wr_row_seq #(.SET_W(SET_W), .ROW_W(ROW_W), .ROWS(ROWS), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .win(win), .idle(idle_phase), .cur_set(wset),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dac_wr(dac_wr), .dac_row(dac_row), .dac_data(dac_data), .dac_ack(dac_ack)
  );

  wr_row_watchdog #(.ROWS(ROWS), .ROW_W(ROW_W), .AGE_W(AGE_W)) u_wd (
    .clk(clk), .rst(rst), .wr(dac_wr), .wr_row(dac_row), .limit(wd_limit),
    .alarm_q(wd_alarm)
  );
endmodule

// File: rtl/wset_refresh_seq_chk.sv
module wset_refresh_seq_chk #(
  parameter int ROW_W  = 5,
  parameter int ADDR_W = 8,
  parameter int SET_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              step_i,
  input logic              idle_phase,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              dac_wr,
  input logic [ROW_W-1:0]  dac_row,
  input logic              dac_ack,
  input logic [SET_W-1:0]  wset
);
  logic pending;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else if (dac_ack) pending <= 1'b0;
    else if (dac_wr) pending <= 1'b1;
  end

  assert_rd_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  assert_wr_follows_rd_R6: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> ##2 dac_wr);

  assert_row_matches_addr_R5: assert property (@(posedge clk) disable iff (rst)
    dac_wr |-> dac_row == $past(mem_addr[ROW_W-1:0], 2));

  assert_rd_in_idle_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> $past(idle_phase));

  assert_single_flight_R7: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> !pending);

  assert_set_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(wset));
endmodule

bind wset_refresh_seq wset_refresh_seq_chk #(.ROW_W(ROW_W), .ADDR_W(ADDR_W), .SET_W(SET_W)) u_chk (
  .clk(clk), .rst(rst), .step_i(step_i), .idle_phase(idle_phase),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .dac_wr(dac_wr), .dac_row(dac_row),
  .dac_ack(dac_ack), .wset(wset)
);

// File: tb/wset_refresh_seq_bench.sv
module wset_refresh_seq_bench;
  localparam int ROWS = 32;
  localparam int ACK_LAT = 12;
  localparam int FRAME = 64;
  localparam int IDLE_FROM = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_i = 1'b0;
  logic [1:0] bin_i = '0;
  logic [15:0] ctl_i = '0;
  logic [15:0] thr_i = {8'd200, 8'd100};
  logic cfg_we = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [5:0] cfg_data = '0;
  logic idle_phase = 1'b0;
  logic [3:0] frame_gap = '0;
  logic [15:0] wd_limit = 16'd2500;
  logic mem_rd;
  logic [7:0] mem_addr;
  logic [255:0] mem_rdata = '0;
  logic dac_wr;
  logic [4:0] dac_row;
  logic [255:0] dac_data;
  logic dac_ack = 1'b0;
  logic [2:0] fsa_state;
  logic [2:0] wset;
  logic wd_alarm;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  wset_refresh_seq u_wset_refresh_seq (
    .clk(clk), .rst(rst), .step_i(step_i), .bin_i(bin_i), .ctl_i(ctl_i), .thr_i(thr_i),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .idle_phase(idle_phase),
    .frame_gap(frame_gap), .wd_limit(wd_limit), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .dac_wr(dac_wr), .dac_row(dac_row), .dac_data(dac_data),
    .dac_ack(dac_ack), .fsa_state(fsa_state), .wset(wset), .wd_alarm(wd_alarm)
  );

  function automatic logic [255:0] row_word(input int a);
    logic [255:0] w;
    for (int c = 0; c < 32; c++) w[c*8 +: 8] = 8'(a * 7 + c * 13 + 5);
    return w;
  endfunction

  // weight memory: one-cycle read latency
  always @(posedge clk) if (mem_rd) mem_rdata <= row_word(int'(mem_addr));

  // reference model state
  int tbl [128];
  int m_state, m_set, m_fcnt, m_win, m_idleq, m_st, m_row, m_rowset;
  int m_rd, m_addr, m_wr, m_drow, m_alarm;
  logic [255:0] m_ddata;
  int m_age [ROWS];
  int cov_wrap = 0, cov_newset = 0, cov_late = 0, cov_alarm = 0;

  always @(posedge clk) begin
    int o_set, o_state, o_win, o_st, a, vec, e;
    if (rst) begin
      m_state = 0; m_set = 0; m_fcnt = 0; m_win = 0; m_idleq = 0; m_st = 0;
      m_row = 0; m_rowset = 0; m_rd = 0; m_addr = 0; m_wr = 0; m_drow = 0;
      m_alarm = 0; m_ddata = '0;
      for (int r = 0; r < ROWS; r++) m_age[r] = 0;
      if (cfg_we) tbl[cfg_addr] = int'(cfg_data);
    end else begin
      o_set = m_set; o_state = m_state; o_win = m_win; o_st = m_st;
      a = 0;
      for (int r = 0; r < ROWS; r++) if (m_age[r] >= int'(wd_limit)) a = 1;
      for (int r = 0; r < ROWS; r++) begin
        if (m_wr == 1 && m_drow == r) m_age[r] = 0;
        else if (m_age[r] < 65535) m_age[r]++;
      end
      m_alarm = a;
      if (a == 1) cov_alarm++;
      if (step_i) begin
        vec = ((ctl_i[15:8] > thr_i[15:8]) ? 8 : 0) + ((ctl_i[7:0] > thr_i[7:0]) ? 4 : 0) + int'(bin_i);
        e = tbl[o_state * 16 + vec];
        m_state = e / 8;
        m_set = e % 8;
      end
      if (cfg_we) tbl[cfg_addr] = int'(cfg_data);
      if (idle_phase && m_idleq == 0) begin
        m_win = (m_fcnt == 0) ? 1 : 0;
        m_fcnt = (m_fcnt >= int'(frame_gap)) ? 0 : m_fcnt + 1;
      end else if (!idle_phase) m_win = 0;
      m_idleq = idle_phase ? 1 : 0;
      if ((o_st == 2 || o_st == 3) && !idle_phase) cov_late++;
      case (o_st)
        0: if (o_win == 1 && idle_phase) begin
          m_rd = 1; m_addr = o_set * ROWS + m_row; m_rowset = o_set; m_st = 1;
        end
        1: begin m_rd = 0; m_st = 2; end
        2: begin m_wr = 1; m_ddata = row_word(m_addr); m_drow = m_row; m_st = 3; end
        default: begin
          m_wr = 0;
          if (dac_ack) begin
            if (o_set != m_rowset) begin m_row = 0; cov_newset++; end
            else begin
              if (m_row == ROWS - 1) cov_wrap++;
              m_row = (m_row + 1) % ROWS;
            end
            m_st = 0;
          end
        end
      endcase
    end
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst) begin
      cmp("R1", "outputs cleared", int'(mem_rd) + int'(dac_wr) + int'(fsa_state) + int'(wset)
          + int'(wd_alarm) + int'(mem_addr) + int'(dac_row) + int'(|dac_data), 0);
    end else begin
      cmp("R2", "fsa_state", int'(fsa_state), m_state);
      cmp("R3", "wset", int'(wset), m_set);
      cmp("R4", "mem_rd", int'(mem_rd), m_rd);
      cmp("R5", "mem_addr", int'(mem_addr), m_addr);
      cmp("R6", "dac_wr", int'(dac_wr), m_wr);
      cmp("R8", "dac_row", int'(dac_row), m_drow);
      compared++;
      if (dac_data !== m_ddata) begin
        mismatched++;
        $display("FAIL R6 dac_data actual %h expected %h", dac_data, m_ddata);
      end
      cmp("R10", "wd_alarm", int'(wd_alarm), m_alarm);
    end
  end

  // frame phase generator
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % FRAME;
      idle_phase = (ph >= IDLE_FROM);
    end
  end

  // converter bank: acknowledge a fixed time after each write
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt == 1) begin dac_ack = 1'b1; cnt = 0; end
      else begin dac_ack = 1'b0; if (cnt > 1) cnt--; end
      if (dac_wr) cnt = ACK_LAT;
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic do_step(input int k);
    bin_i = 2'(k);
    ctl_i[7:0] = (k % 5 == 0) ? 8'd100 : 8'(k * 37);
    ctl_i[15:8] = (k % 7 == 0) ? 8'd200 : 8'(k * 53 + 11);
    step_i = 1'b1;
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic cov(input string req, input string what, input int n);
    compared++;
    if (n <= 0) begin
      mismatched++;
      $display("FAIL %s %s actual %0d expected >0", req, what, n);
    end
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(negedge clk);
    mismatched++;
    $display("FAIL watchdog run did not finish actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 7'(s * 16 + v);
        cfg_data = {3'((s + v) % 8), 3'((s * 3 + v) % 8)};
      end
    end
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 R9: every-frame refresh with steps at irregular times
    frame_gap = 4'd0;
    for (int k = 1; k <= 40; k++) begin
      repeat (90 + (k % 11)) @(negedge clk);
      do_step(k);
    end
    // R4: one window in three
    frame_gap = 4'd2;
    for (int k = 41; k <= 80; k++) begin
      repeat (80 + (k % 13)) @(negedge clk);
      do_step(k);
    end
    // R3 R8: no steps, rows wrap
    frame_gap = 4'd0;
    wd_limit = 16'd3000;
    repeat (5000) @(negedge clk);
    cov("R8", "row wraps", cov_wrap);
    cov("R9", "set changes in flight", cov_newset);
    cov("R11", "rows finishing after idle", cov_late);
    cov("R10", "alarm cycles", cov_alarm);
    finish_run();
  end
endmodule